// File: doc/BRIEF.md
# State Save Instruction Fault Checker

This block decides, for one state-save request, whether the save may go ahead or which single fault it must raise. It looks at the operating mode, the effective address of the save area, segment and stack hints from the address unit, the instruction's prefix, feature and control bits, and the alignment-check setup. One cycle after a request it returns either a proceed flag or exactly one bit of a five-bit fault vector. It also captures the requested-component mask from the two 64-bit mask registers, keeping only the low half of each.

The address checks depend on the mode. Every mode requires the save area to sit on a 64-byte boundary. Long mode also demands a canonical address. Protected mode honours a segment-limit violation flag. Real mode rejects a save area that runs past the top of the 64 KiB space. Page faults and the save itself belong to other blocks.

Top module: `save_fault_chk`

## Requirements
- R1: While rst_n is low, resp_o, proceed_o, fault_o and mask_o are all zero.
- R2: A request on req_i gives resp_o=1 in the next cycle. proceed_o is 1 exactly when that response carries no fault. In cycles with no response, fault_o is zero and proceed_o is 0.
- R3: An undefined-opcode fault is reported (fault_o = 5'b00001, bit 0) when lock_i is 1, when either feature flag is 0, or when os_en_i is 0.
- R4: When no R3 cause is present and ts_i is 1, a device-not-available fault is reported (fault_o = 5'b00010, bit 1).
- R5: In every mode, a nonzero value in ea_i[5:0] raises a general-protection fault (fault_o = 5'b00100, bit 2), except in the case covered by R6.
- R6: A misaligned address raises an alignment-check fault (fault_o = 5'b10000, bit 4) when ac_en_i is 1 and cpl_i is 3.
- R7: In long mode (mode_i = 2'b10), an address whose bits 63..47 are not all equal is non-canonical. It raises a stack fault (fault_o = 5'b01000, bit 3) when stk_seg_i is 1, and a general-protection fault otherwise. In other modes these bits are ignored.
- R8: In protected mode (mode_i = 2'b01 or 2'b11), seg_viol_i raises a stack fault when stk_seg_i is 1 and a general-protection fault otherwise. In real and long mode, seg_viol_i is ignored.
- R9: In real mode (mode_i = 2'b00), a 576-byte save area starting at ea_i[31:0] that reaches past address 0xFFFF raises a general-protection fault.
- R10: The faults rank as follows: undefined-opcode first, then device-not-available, then alignment, then canonical and limit faults. Only the highest-ranked fault is reported, so fault_o is never more than one-hot.
- R11: On a request, mask_o takes the value {rdx_i[31:0], rax_i[31:0]}. The upper 32 bits of both mask inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Check request |
| mode_i | input | 2 | 00 real, 01/11 protected, 10 long |
| ea_i | input | 64 | Effective address of the save area |
| seg_viol_i | input | 1 | Segment-limit violation detected |
| stk_seg_i | input | 1 | Access uses the stack segment |
| lock_i | input | 1 | Lock prefix present |
| feat_base_i | input | 1 | Base extended-save feature present |
| feat_cmp_i | input | 1 | Compacted-save feature present |
| os_en_i | input | 1 | OS enable for extended state |
| ts_i | input | 1 | Task-switched control bit |
| ac_en_i | input | 1 | Alignment checking enabled |
| cpl_i | input | 2 | Current privilege level |
| rdx_i | input | 64 | Upper mask register |
| rax_i | input | 64 | Lower mask register |
| resp_o | output | 1 | Response valid |
| fault_o | output | 5 | One-hot fault: bit0 UD, bit1 NM, bit2 GP, bit3 SS, bit4 AC |
| proceed_o | output | 1 | Save may proceed |
| mask_o | output | 64 | Requested-component mask |

## Verification
The alignment check and the mode-specific address check can both fire on the same request. The bench provokes this with a misaligned address that is also non-canonical with the stack segment flagged. It does the same with a misaligned protected-mode address that also has a stack-segment limit violation. In both cases the bench expects a lone general-protection bit and never the stack bit. It also pairs the task-switched bit with a misalignment and expects the device-not-available fault on its own.

// File: rtl/save_fault_chk.sv
module save_fault_chk #(
  parameter int ADDR_W     = 64,
  parameter int VA_W       = 48,
  parameter int ALIGN_LOG2 = 6,
  parameter int AREA_BYTES = 576,
  parameter int REAL_SPAN  = 65536,
  parameter int HALF_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [1:0]          mode_i,
  input  logic [ADDR_W-1:0]   ea_i,
  input  logic                seg_viol_i,
  input  logic                stk_seg_i,
  input  logic                lock_i,
  input  logic                feat_base_i,
  input  logic                feat_cmp_i,
  input  logic                os_en_i,
  input  logic                ts_i,
  input  logic                ac_en_i,
  input  logic [1:0]          cpl_i,
  input  logic [ADDR_W-1:0]   rdx_i,
  input  logic [ADDR_W-1:0]   rax_i,
  output logic                resp_o,
  output logic [4:0]          fault_o,
  output logic                proceed_o,
  output logic [2*HALF_W-1:0] mask_o
);
  localparam logic [1:0] M_REAL = 2'b00;
  localparam logic [1:0] M_LONG = 2'b10;
  localparam int TOP_W = ADDR_W - VA_W + 1;

  wire is_real = (mode_i == M_REAL);
  wire is_long = (mode_i == M_LONG);
  wire is_prot = !is_real && !is_long;

  wire ud      = lock_i | ~feat_base_i | ~feat_cmp_i | ~os_en_i;
  wire misal   = |ea_i[ALIGN_LOG2-1:0];
  wire ac_path = ac_en_i && (cpl_i == 2'd3);

  wire [TOP_W-1:0] top_bits = ea_i[ADDR_W-1:VA_W-1];
  wire noncanon = is_long && !((&top_bits) || !(|top_bits));
  wire prot_lim = is_prot && seg_viol_i;

  logic [HALF_W:0] real_end;
  assign real_end = {1'b0, ea_i[HALF_W-1:0]} + (HALF_W+1)'(AREA_BYTES);
  wire real_over = is_real && (real_end > (HALF_W+1)'(REAL_SPAN));

  logic [4:0] nxt;
  always_comb begin
    nxt = '0;
    if (ud)                       nxt[0] = 1'b1;
    else if (ts_i)                nxt[1] = 1'b1;
    else if (misal)               nxt[ac_path ? 4 : 2] = 1'b1;
    else if (noncanon || prot_lim) nxt[stk_seg_i ? 3 : 2] = 1'b1;
    else if (real_over)           nxt[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_o    <= 1'b0;
      fault_o   <= '0;
      proceed_o <= 1'b0;
      mask_o    <= '0;
    end else begin
      resp_o    <= req_i;
      fault_o   <= req_i ? nxt : 5'b0;
      proceed_o <= req_i && (nxt == 5'b0);
      if (req_i) mask_o <= {rdx_i[HALF_W-1:0], rax_i[HALF_W-1:0]};
    end
  end
endmodule

module save_fault_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        lock_i,
  input logic        feat_base_i,
  input logic        feat_cmp_i,
  input logic        os_en_i,
  input logic        ts_i,
  input logic [63:0] rdx_i,
  input logic [63:0] rax_i,
  input logic        resp_o,
  input logic [4:0]  fault_o,
  input logic        proceed_o,
  input logic [63:0] mask_o
);
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> resp_o);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_o |-> (fault_o == 5'b0) && !proceed_o);
  assert_proceed_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    proceed_o |-> (fault_o == 5'b0));
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_o));
  assert_lock_ud_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && lock_i) |=> (fault_o == 5'b00001));
  assert_ts_nm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ts_i && !lock_i && feat_base_i && feat_cmp_i && os_en_i) |=> (fault_o == 5'b00010));
  assert_mask_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (mask_o == {$past(rdx_i[31:0]), $past(rax_i[31:0])}));
endmodule

bind save_fault_chk save_fault_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .lock_i(lock_i),
  .feat_base_i(feat_base_i), .feat_cmp_i(feat_cmp_i), .os_en_i(os_en_i),
  .ts_i(ts_i), .rdx_i(rdx_i), .rax_i(rax_i), .resp_o(resp_o),
  .fault_o(fault_o), .proceed_o(proceed_o), .mask_o(mask_o)
);

// File: tb/save_fault_chk_tb.sv
module save_fault_chk_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] F_NONE = 5'b00000, F_UD = 5'b00001, F_NM = 5'b00010,
                         F_GP = 5'b00100, F_SS = 5'b01000, F_AC = 5'b10000;

  logic clk = 0, rst_n = 0, req = 0;
  logic [1:0] mode;
  logic [63:0] ea, rdx, rax;
  logic seg_viol, stk, lock, fb, fc, osen, ts, acen;
  logic [1:0] cpl;
  logic resp, proceed;
  logic [4:0] fault;
  logic [63:0] mask;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  save_fault_chk u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .ea_i(ea),
    .seg_viol_i(seg_viol), .stk_seg_i(stk), .lock_i(lock), .feat_base_i(fb),
    .feat_cmp_i(fc), .os_en_i(osen), .ts_i(ts), .ac_en_i(acen), .cpl_i(cpl),
    .rdx_i(rdx), .rax_i(rax), .resp_o(resp), .fault_o(fault),
    .proceed_o(proceed), .mask_o(mask));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    mode = 2'b01; ea = 64'h1000; seg_viol = 0; stk = 0; lock = 0;
    fb = 1; fc = 1; osen = 1; ts = 0; acen = 0; cpl = 0;
    rdx = 0; rax = 0;
  endtask

  task automatic apply(input string tag, input logic [4:0] exp);
    @(negedge clk) req = 1;
    @(negedge clk) req = 0;
    check({tag, " resp"}, {63'b0, resp}, 64'd1);
    check({tag, " fault"}, {59'b0, fault}, {59'b0, exp});
    check({tag, " proceed"}, {63'b0, proceed}, {63'b0, exp == F_NONE});
    defaults();
  endtask

  task automatic t_reset();
    defaults();
    repeat (2) @(negedge clk);
    check("R1 reset", {resp, proceed, fault, mask[56:0]}, 64'd0);
    rst_n = 1;
  endtask

  task automatic t_clean();
    apply("R2 clean prot", F_NONE);
    mode = 2'b10; ea = 64'hFFFF_8000_0000_0040; apply("R2 clean long", F_NONE);
    mode = 2'b00; ea = 64'h0000_0000_0000_FDC0; apply("R2/R9 real top fits", F_NONE);
    @(negedge clk);
    check("R2 idle", {61'b0, resp, proceed, |fault}, 64'd0);
  endtask

  task automatic t_ud();
    lock = 1; apply("R3 lock", F_UD);
    fb = 0; apply("R3 base feat", F_UD);
    fc = 0; apply("R3 cmp feat", F_UD);
    osen = 0; apply("R3 os enable", F_UD);
  endtask

  task automatic t_nm();
    ts = 1; apply("R4 ts", F_NM);
    ts = 1; osen = 0; apply("R10 ud over nm", F_UD);
  endtask

  task automatic t_align();
    ea = 64'h1008; apply("R5 prot misaligned", F_GP);
    mode = 2'b00; ea = 64'h0001; apply("R5 real misaligned", F_GP);
    mode = 2'b10; ea = 64'h1020; apply("R5 long misaligned", F_GP);
  endtask

  task automatic t_ac();
    ea = 64'h1004; acen = 1; cpl = 3; apply("R6 ac cpl3", F_AC);
    ea = 64'h1004; acen = 1; cpl = 0; apply("R6 ac cpl0 gp", F_GP);
    ea = 64'h1004; acen = 0; cpl = 3; apply("R6 ac off gp", F_GP);
  endtask

  task automatic t_canon();
    mode = 2'b10; ea = 64'h0000_8000_0000_0000; apply("R7 noncanon gp", F_GP);
    mode = 2'b10; ea = 64'h0000_8000_0000_0000; stk = 1; apply("R7 noncanon ss", F_SS);
    mode = 2'b10; ea = 64'hFFFF_7FFF_FFFF_FFC0; apply("R7 neg noncanon", F_GP);
    ea = 64'h0000_8000_0000_0000; apply("R7 prot ignores top", F_NONE);
  endtask

  task automatic t_limit();
    seg_viol = 1; apply("R8 limit gp", F_GP);
    seg_viol = 1; stk = 1; apply("R8 limit ss", F_SS);
    mode = 2'b11; seg_viol = 1; stk = 1; apply("R8 mode3 ss", F_SS);
    mode = 2'b10; seg_viol = 1; stk = 1; apply("R8 long ignores", F_NONE);
    mode = 2'b00; seg_viol = 1; apply("R8 real ignores", F_NONE);
  endtask

  task automatic t_real();
    mode = 2'b00; ea = 64'hFE00; apply("R9 real over", F_GP);
    mode = 2'b00; ea = 64'h0001_0000; apply("R9 real high", F_GP);
  endtask

  task automatic t_prio();
    mode = 2'b10; ea = 64'h0000_8000_0000_0008; stk = 1; apply("R10 align over canon", F_GP);
    ea = 64'h1010; seg_viol = 1; stk = 1; apply("R10 align over limit", F_GP);
    ts = 1; ea = 64'h1010; apply("R10 nm over align", F_NM);
  endtask

  task automatic t_mask();
    rdx = 64'hDEAD_BEEF_1234_5678; rax = 64'hCAFE_F00D_9ABC_DEF0;
    apply("R11 mask", F_NONE);
    check("R11 mask value", mask, 64'h1234_5678_9ABC_DEF0);
    rdx = 64'hFFFF_FFFF_0000_0001; rax = 64'h0;
    apply("R11 mask upper ignored", F_NONE);
    check("R11 mask value2", mask, 64'h0000_0001_0000_0000);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_ud();
    t_nm();
    t_align();
    t_ac();
    t_canon();
    t_limit();
    t_real();
    t_prio();
    t_mask();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule